// File: doc/BRIEF.md
# Fetch-Line Branch Target Predictor

This block predicts, once per fetch cycle, where an aligned 16-byte fetch line leaves sequential flow. The fetch address is split into a line offset, a set index and a tag. All ways of the selected set are compared against the tag, and several ways may hit at once. Hits whose stored branch offset lies before the fetch offset are skipped. Among the rest, the branch with the lowest offset that is predicted taken wins. The block then reports the taken flag, the target, the branch kind, the branch offset and the history that was used. When no branch is taken, the prediction is the next sequential line.

Direction comes from a two-level local scheme. Each entry keeps a short history of its own outcomes. That history selects one of a row of 2-bit saturating counters owned by the set, and the counter's top bit gives the direction. When a prediction is made, the history of each conditional branch that the fetch walks over is shifted speculatively. A separate update port takes resolved branches. It repairs the history of a matching entry from the snapshot the caller passes back. On a miss it allocates a new entry, and for conditional branches it trains the counter.

Top module: `ftb_predictor`

## Requirements
- R1: With default parameters, the address fields are offset = addr[3:0], set = addr[10:4] and tag = addr[31:11]. A way hits only if it is valid and its tag equals the fetch tag.
- R2: After reset pred_valid is 0. A lookup presented with fetch_valid=1 before a clock edge shows pred_valid=1 and its results after that edge; fetch_valid=0 gives pred_valid=0.
- R3: A hitting way whose stored offset is lower than the fetch offset is never selected.
- R4: Among the remaining hits predicted taken, the one with the lowest stored offset is reported (pred_taken=1, pred_target, pred_type, pred_ofs). On equal offsets the lower way index wins.
- R5: If no eligible hit is predicted taken, the outputs are pred_taken=0, pred_target = (line address + 1) with offset bits 0, pred_type=0, pred_ofs=0 and pred_hist=0.
- R6: A conditional branch (type 00) is predicted taken when bit 1 of its set's counter, at index = the entry's 4-bit history, is 1. All counters reset to 01. A conditional update moves counter[set][upd_hist] up by one if taken and down by one if not, saturating at 00 and 11.
- R7: Types 01 (return), 10 (call) and 11 (unconditional) are always predicted taken. pred_use_ras=1 exactly when the reported branch is a return.
- R8: At a lookup, every eligible conditional hit with offset below the selected one, plus the selected one if conditional, shifts its predicted direction into the history LSB (history = {history[2:0], direction}). With no selection, this applies to all eligible conditional hits.
- R9: An update whose address matches a valid entry (same tag, set and offset) sets that entry's history to {upd_hist[2:0], upd_taken} and refreshes its type and target.
- R10: An update that matches no entry allocates the set's round-robin way. The pointer starts at way 0 after reset and advances by one per allocation. The new entry stores the offset, type and target, with history 0.
- R11: A lookup in the same cycle as an update reads the state from before that edge. If both write the same entry, the update's value is kept.
- R12: pred_hist reports the selected entry's history as it was before the speculative shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | Lookup request this cycle |
| fetch_addr | input | 32 | Fetch address |
| upd_valid | input | 1 | Resolved-branch update this cycle |
| upd_addr | input | 32 | Address of the resolved branch |
| upd_taken | input | 1 | Actual outcome |
| upd_type | input | 2 | Branch kind: 00 cond, 01 return, 10 call, 11 unconditional |
| upd_target | input | 32 | Resolved target |
| upd_hist | input | 4 | History snapshot the prediction used |
| pred_valid | output | 1 | Prediction valid |
| pred_taken | output | 1 | A branch in the line is predicted taken |
| pred_target | output | 32 | Predicted next fetch address |
| pred_type | output | 2 | Kind of the selected branch |
| pred_ofs | output | 4 | Line offset of the selected branch |
| pred_use_ras | output | 1 | Target must come from a return stack |
| pred_hist | output | 4 | History of the selected entry before the shift |

## Verification
Every prediction is due one clock edge after its lookup is presented. The bench drives stimulus on the falling edge and checks the registered result on the next falling edge. An update takes effect at the same edge as a lookup issued alongside it. That lookup still sees the old state, so its effect first shows on the lookup presented in the following cycle. The bench model follows this order: it computes the prediction from the pre-edge state, applies the speculative history writes, and then applies the update on top of them.

// File: rtl/ftb_pkg.sv
package ftb_pkg;
  typedef enum logic [1:0] {
    BR_COND = 2'b00,
    BR_RET  = 2'b01,
    BR_CALL = 2'b10,
    BR_JMP  = 2'b11
  } br_kind_e;
endpackage

// File: rtl/ftb_ctr_bank.sv
module ftb_ctr_bank #(
  parameter int SETS   = 128,
  parameter int HIST_W = 4,
  parameter int CTR_W  = 2
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [$clog2(SETS)-1:0]          rd_set,
  output logic [(1<<HIST_W)*CTR_W-1:0]     rd_row,
  input  logic                             trn_en,
  input  logic [$clog2(SETS)-1:0]          trn_set,
  input  logic [HIST_W-1:0]                trn_idx,
  input  logic                             trn_taken
);
  localparam int NCTR  = 1 << HIST_W;
  localparam int ROW_W = NCTR * CTR_W;
  localparam logic [CTR_W-1:0] CTR_INIT = CTR_W'((1 << (CTR_W-1)) - 1);
  localparam logic [CTR_W-1:0] CTR_MAX  = '1;
  localparam logic [CTR_W-1:0] CTR_MIN  = '0;

  logic [ROW_W-1:0] mem [SETS];
  logic [ROW_W-1:0] trn_row, trn_row_nxt;
  logic [CTR_W-1:0] trn_cur, trn_nxt;

  assign rd_row = mem[rd_set];

  always_comb begin
    trn_row = mem[trn_set];
    trn_cur = trn_row[trn_idx*CTR_W +: CTR_W];
    trn_nxt = trn_cur;
    if (trn_taken && trn_cur != CTR_MAX)
      trn_nxt = trn_cur + CTR_W'(1);
    else if (!trn_taken && trn_cur != CTR_MIN)
      trn_nxt = trn_cur - CTR_W'(1);
    trn_row_nxt = trn_row;
    trn_row_nxt[trn_idx*CTR_W +: CTR_W] = trn_nxt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) mem[s] <= {NCTR{CTR_INIT}};
    end else if (trn_en) begin
      mem[trn_set] <= trn_row_nxt;
    end
  end
endmodule

// File: rtl/ftb_way_select.sv
module ftb_way_select #(
  parameter int WAYS  = 4,
  parameter int OFS_W = 4,
  parameter int WAY_W = 2
) (
  input  logic [OFS_W-1:0]      fetch_ofs,
  input  logic [WAYS-1:0]       hit,
  input  logic [WAYS*OFS_W-1:0] way_ofs,
  input  logic [WAYS-1:0]       way_dir,
  output logic                  found,
  output logic [WAY_W-1:0]      sel_way,
  output logic [OFS_W-1:0]      sel_ofs,
  output logic [WAYS-1:0]       reach
);
  logic [WAYS-1:0] elig;

  generate
    for (genvar w = 0; w < WAYS; w++) begin : g_elig
      assign elig[w] = hit[w] && (way_ofs[w*OFS_W +: OFS_W] >= fetch_ofs);
    end
  endgenerate

  always_comb begin
    found   = 1'b0;
    sel_way = '0;
    sel_ofs = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (elig[w] && way_dir[w] &&
          (!found || way_ofs[w*OFS_W +: OFS_W] < sel_ofs)) begin
        found   = 1'b1;
        sel_way = WAY_W'(w);
        sel_ofs = way_ofs[w*OFS_W +: OFS_W];
      end
    end
    for (int w = 0; w < WAYS; w++) begin
      reach[w] = elig[w] &&
                 (!found || way_ofs[w*OFS_W +: OFS_W] < sel_ofs ||
                  sel_way == WAY_W'(w));
    end
  end
endmodule

// File: rtl/ftb_predictor.sv
module ftb_predictor
  import ftb_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WAYS       = 4,
  parameter int SETS       = 128,
  parameter int LINE_BYTES = 16,
  parameter int HIST_W     = 4,
  parameter int CTR_W      = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          fetch_valid,
  input  logic [ADDR_W-1:0]             fetch_addr,
  input  logic                          upd_valid,
  input  logic [ADDR_W-1:0]             upd_addr,
  input  logic                          upd_taken,
  input  logic [1:0]                    upd_type,
  input  logic [ADDR_W-1:0]             upd_target,
  input  logic [HIST_W-1:0]             upd_hist,
  output logic                          pred_valid,
  output logic                          pred_taken,
  output logic [ADDR_W-1:0]             pred_target,
  output logic [1:0]                    pred_type,
  output logic [$clog2(LINE_BYTES)-1:0] pred_ofs,
  output logic                          pred_use_ras,
  output logic [HIST_W-1:0]             pred_hist
);
  localparam int OFS_W  = $clog2(LINE_BYTES);
  localparam int SET_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - OFS_W - SET_W;
  localparam int LINE_W = ADDR_W - OFS_W;
  localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int ROW_W  = (1 << HIST_W) * CTR_W;

  // address fields
  logic [OFS_W-1:0] f_ofs, u_ofs;
  logic [SET_W-1:0] f_set, u_set;
  logic [TAG_W-1:0] f_tag, u_tag;
  assign f_ofs = fetch_addr[OFS_W-1:0];
  assign f_set = fetch_addr[OFS_W +: SET_W];
  assign f_tag = fetch_addr[ADDR_W-1 -: TAG_W];
  assign u_ofs = upd_addr[OFS_W-1:0];
  assign u_set = upd_addr[OFS_W +: SET_W];
  assign u_tag = upd_addr[ADDR_W-1 -: TAG_W];

  // entry storage, one array per field
  logic [TAG_W-1:0]  tag_mem  [WAYS][SETS];
  logic [OFS_W-1:0]  ofs_mem  [WAYS][SETS];
  logic [1:0]        kind_mem [WAYS][SETS];
  logic [ADDR_W-1:0] tgt_mem  [WAYS][SETS];
  logic [HIST_W-1:0] hist_mem [WAYS][SETS];
  logic [SETS-1:0]   valid_q  [WAYS];
  logic [WAY_W-1:0]  rr_q     [SETS];

  // lookup side reads
  logic [TAG_W-1:0]     rd_tag  [WAYS];
  logic [1:0]           rd_kind [WAYS];
  logic [ADDR_W-1:0]    rd_tgt  [WAYS];
  logic [HIST_W-1:0]    rd_hist [WAYS];
  logic [WAYS-1:0]      f_hit, way_dir, reach, spec_we;
  logic [WAYS*OFS_W-1:0] rd_ofs_flat;
  logic [ROW_W-1:0]     ctr_row;

  // update side reads
  logic [WAYS-1:0]  u_hit_w, upd_we;
  logic             u_hit_any, u_alloc;
  logic [WAY_W-1:0] u_way;
  logic [HIST_W-1:0] u_hist_new;

  generate
    for (genvar w = 0; w < WAYS; w++) begin : g_rd
      assign rd_tag[w]  = tag_mem[w][f_set];
      assign rd_kind[w] = kind_mem[w][f_set];
      assign rd_tgt[w]  = tgt_mem[w][f_set];
      assign rd_hist[w] = hist_mem[w][f_set];
      assign rd_ofs_flat[w*OFS_W +: OFS_W] = ofs_mem[w][f_set];
      assign f_hit[w]   = valid_q[w][f_set] && (rd_tag[w] == f_tag);
      assign way_dir[w] = (rd_kind[w] != BR_COND) ||
                          ctr_row[rd_hist[w]*CTR_W + CTR_W - 1];
      assign spec_we[w] = fetch_valid && reach[w] && (rd_kind[w] == BR_COND);
      assign u_hit_w[w] = valid_q[w][u_set] && (tag_mem[w][u_set] == u_tag) &&
                          (ofs_mem[w][u_set] == u_ofs);
      assign upd_we[w]  = upd_valid &&
                          (u_hit_any ? (u_way == WAY_W'(w)) : (rr_q[u_set] == WAY_W'(w)));
    end
  endgenerate

  always_comb begin
    u_hit_any = 1'b0;
    u_way     = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (u_hit_w[w]) begin
        u_hit_any = 1'b1;
        u_way     = WAY_W'(w);
      end
    end
  end

  assign u_alloc    = upd_valid && !u_hit_any;
  assign u_hist_new = u_hit_any ? {upd_hist[HIST_W-2:0], upd_taken} : '0;

  logic             sel_found;
  logic [WAY_W-1:0] sel_way;
  logic [OFS_W-1:0] sel_ofs;

  ftb_way_select #(
    .WAYS (WAYS),
    .OFS_W(OFS_W),
    .WAY_W(WAY_W)
  ) u_sel (
    .fetch_ofs(f_ofs),
    .hit      (f_hit),
    .way_ofs  (rd_ofs_flat),
    .way_dir  (way_dir),
    .found    (sel_found),
    .sel_way  (sel_way),
    .sel_ofs  (sel_ofs),
    .reach    (reach)
  );

  ftb_ctr_bank #(
    .SETS  (SETS),
    .HIST_W(HIST_W),
    .CTR_W (CTR_W)
  ) u_ctr (
    .clk      (clk),
    .rst      (rst),
    .rd_set   (f_set),
    .rd_row   (ctr_row),
    .trn_en   (upd_valid && (upd_type == BR_COND)),
    .trn_set  (u_set),
    .trn_idx  (upd_hist),
    .trn_taken(upd_taken)
  );

  // payload writes: speculative shift first, update last so it wins
  always_ff @(posedge clk) begin
    for (int w = 0; w < WAYS; w++) begin
      if (spec_we[w])
        hist_mem[w][f_set] <= {rd_hist[w][HIST_W-2:0], way_dir[w]};
      if (upd_we[w]) begin
        hist_mem[w][u_set] <= u_hist_new;
        kind_mem[w][u_set] <= upd_type;
        tgt_mem[w][u_set]  <= upd_target;
        if (!u_hit_any) begin
          tag_mem[w][u_set] <= u_tag;
          ofs_mem[w][u_set] <= u_ofs;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int w = 0; w < WAYS; w++) valid_q[w] <= '0;
      for (int s = 0; s < SETS; s++) rr_q[s] <= '0;
    end else begin
      for (int w = 0; w < WAYS; w++)
        if (upd_we[w]) valid_q[w][u_set] <= 1'b1;
      if (u_alloc) rr_q[u_set] <= rr_q[u_set] + WAY_W'(1);
    end
  end

  // registered prediction
  always_ff @(posedge clk) begin
    if (rst) begin
      pred_valid   <= 1'b0;
      pred_taken   <= 1'b0;
      pred_target  <= '0;
      pred_type    <= '0;
      pred_ofs     <= '0;
      pred_use_ras <= 1'b0;
      pred_hist    <= '0;
    end else begin
      pred_valid <= fetch_valid;
      pred_taken <= sel_found;
      if (sel_found) begin
        pred_target  <= rd_tgt[sel_way];
        pred_type    <= rd_kind[sel_way];
        pred_ofs     <= sel_ofs;
        pred_use_ras <= (rd_kind[sel_way] == BR_RET);
        pred_hist    <= rd_hist[sel_way];
      end else begin
        pred_target  <= {fetch_addr[ADDR_W-1:OFS_W] + LINE_W'(1), {OFS_W{1'b0}}};
        pred_type    <= '0;
        pred_ofs     <= '0;
        pred_use_ras <= 1'b0;
        pred_hist    <= '0;
      end
    end
  end

  // R2: one-edge latency of the valid flag
  p_valid_lat_r2: assert property (@(posedge clk) disable iff (rst)
    fetch_valid |=> pred_valid);
  p_idle_lat_r2: assert property (@(posedge clk) disable iff (rst)
    !fetch_valid |=> !pred_valid);
  // R3: the chosen branch never lies before the fetch offset
  p_ofs_floor_r3: assert property (@(posedge clk) disable iff (rst)
    fetch_valid |=> (!pred_taken || pred_ofs >= $past(f_ofs)));
  // R5: fall-through goes to the next line
  p_fallthru_r5: assert property (@(posedge clk) disable iff (rst)
    fetch_valid |=> (pred_taken ||
      pred_target == {$past(fetch_addr[ADDR_W-1:OFS_W]) + LINE_W'(1), {OFS_W{1'b0}}}));
  // R7: return-stack flag only on a taken return
  p_ras_kind_r7: assert property (@(posedge clk) disable iff (rst)
    pred_use_ras |-> (pred_taken && pred_type == BR_RET));
  // R10: allocation advances the set's round-robin pointer
  p_rr_step_r10: assert property (@(posedge clk) disable iff (rst)
    u_alloc |=> rr_q[$past(u_set)] == $past(rr_q[u_set]) + WAY_W'(1));
endmodule

// File: tb/ftb_predictor_bench.sv
module ftb_predictor_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fetch_valid = 1'b0;
  logic [31:0] fetch_addr = '0;
  logic        upd_valid = 1'b0;
  logic [31:0] upd_addr = '0;
  logic        upd_taken = 1'b0;
  logic [1:0]  upd_type = '0;
  logic [31:0] upd_target = '0;
  logic [3:0]  upd_hist = '0;
  logic        pred_valid, pred_taken, pred_use_ras;
  logic [31:0] pred_target;
  logic [1:0]  pred_type;
  logic [3:0]  pred_ofs, pred_hist;

  ftb_predictor u_ftb_predictor (
    .clk(clk), .rst(rst),
    .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
    .upd_valid(upd_valid), .upd_addr(upd_addr), .upd_taken(upd_taken),
    .upd_type(upd_type), .upd_target(upd_target), .upd_hist(upd_hist),
    .pred_valid(pred_valid), .pred_taken(pred_taken), .pred_target(pred_target),
    .pred_type(pred_type), .pred_ofs(pred_ofs), .pred_use_ras(pred_use_ras),
    .pred_hist(pred_hist)
  );

  always #10 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // reference state
  bit          m_v   [4][128];
  logic [20:0] m_tag [4][128];
  logic [3:0]  m_ofs [4][128];
  logic [1:0]  m_ty  [4][128];
  logic [31:0] m_tg  [4][128];
  logic [3:0]  m_h   [4][128];
  int          m_rr  [128];
  logic [1:0]  m_cnt [128][16];

  // expected outputs of the last lookup
  bit          e_valid = 0, e_taken = 0, e_ras = 0;
  logic [31:0] e_tgt = '0;
  logic [1:0]  e_ty = '0;
  logic [3:0]  e_ofs = '0, e_hist = '0;
  string       e_tag = "R2";

  task automatic chk(string tg, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tg, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int w = 0; w < 4; w++)
      for (int s = 0; s < 128; s++) m_v[w][s] = 0;
    for (int s = 0; s < 128; s++) begin
      m_rr[s] = 0;
      for (int i = 0; i < 16; i++) m_cnt[s][i] = 2'b01;
    end
  endtask

  task automatic model_step(bit fv, logic [31:0] fa, bit uv, logic [31:0] ua,
                            bit ut, logic [1:0] uty, logic [31:0] utg, logic [3:0] uh);
    int fs, us, fo, uo, best, bofs, hw, w;
    logic [20:0] ft, utag;
    bit elig [4];
    bit dir [4];
    bit sw [4];
    fs = int'(fa[10:4]); ft = fa[31:11]; fo = int'(fa[3:0]);
    us = int'(ua[10:4]); utag = ua[31:11]; uo = int'(ua[3:0]);
    best = -1; bofs = 16;
    for (int k = 0; k < 4; k++) begin
      elig[k] = m_v[k][fs] && m_tag[k][fs] == ft && int'(m_ofs[k][fs]) >= fo;
      dir[k]  = (m_ty[k][fs] != 2'b00) || m_cnt[fs][m_h[k][fs]][1];
      if (elig[k] && dir[k] && int'(m_ofs[k][fs]) < bofs) begin
        best = k; bofs = int'(m_ofs[k][fs]);
      end
    end
    e_valid = fv;
    if (fv) begin
      e_taken = (best >= 0);
      if (best >= 0) begin
        e_tgt = m_tg[best][fs]; e_ty = m_ty[best][fs]; e_ofs = m_ofs[best][fs];
        e_ras = (m_ty[best][fs] == 2'b01); e_hist = m_h[best][fs];
      end else begin
        e_tgt = {fa[31:4] + 28'd1, 4'h0}; e_ty = 0; e_ofs = 0; e_ras = 0; e_hist = 0;
      end
    end
    for (int k = 0; k < 4; k++)
      sw[k] = fv && elig[k] && m_ty[k][fs] == 2'b00 &&
              (int'(m_ofs[k][fs]) < bofs || k == best);
    hw = -1;
    for (int k = 0; k < 4; k++)
      if (hw < 0 && m_v[k][us] && m_tag[k][us] == utag && int'(m_ofs[k][us]) == uo) hw = k;
    for (int k = 0; k < 4; k++)
      if (sw[k]) m_h[k][fs] = {m_h[k][fs][2:0], dir[k]};
    if (uv) begin
      if (hw >= 0) begin
        m_h[hw][us] = {uh[2:0], ut}; m_ty[hw][us] = uty; m_tg[hw][us] = utg;
      end else begin
        w = m_rr[us];
        m_v[w][us] = 1; m_tag[w][us] = utag; m_ofs[w][us] = ua[3:0];
        m_h[w][us] = 0; m_ty[w][us] = uty; m_tg[w][us] = utg;
        m_rr[us] = (m_rr[us] + 1) % 4;
      end
      if (uty == 2'b00) begin
        if (ut && m_cnt[us][uh] != 2'b11) m_cnt[us][uh] = m_cnt[us][uh] + 2'd1;
        else if (!ut && m_cnt[us][uh] != 2'b00) m_cnt[us][uh] = m_cnt[us][uh] - 2'd1;
      end
    end
  endtask

  task automatic compare();
    chk(e_tag, "pred_valid", {31'd0, pred_valid}, {31'd0, e_valid});
    if (e_valid) begin
      chk(e_tag, "pred_taken", {31'd0, pred_taken}, {31'd0, e_taken});
      chk(e_tag, "pred_target", pred_target, e_tgt);
      chk(e_tag, "pred_type", {30'd0, pred_type}, {30'd0, e_ty});
      chk(e_tag, "pred_ofs", {28'd0, pred_ofs}, {28'd0, e_ofs});
      chk(e_tag, "pred_use_ras", {31'd0, pred_use_ras}, {31'd0, e_ras});
      chk(e_tag, "pred_hist", {28'd0, pred_hist}, {28'd0, e_hist});
    end
  endtask

  task automatic step(bit fv, logic [31:0] fa, bit uv, logic [31:0] ua, bit ut,
                      logic [1:0] uty, logic [31:0] utg, logic [3:0] uh, string tg);
    @(negedge clk);
    compare();
    fetch_valid = fv; fetch_addr = fa;
    upd_valid = uv; upd_addr = ua; upd_taken = ut;
    upd_type = uty; upd_target = utg; upd_hist = uh;
    model_step(fv, fa, uv, ua, ut, uty, utg, uh);
    e_tag = tg;
  endtask

  function automatic logic [31:0] la(logic [20:0] t, logic [6:0] s, logic [3:0] o);
    return {t, s, o};
  endfunction

  initial begin
    int seed;
    seed = 32'h5EED;
    void'($urandom(seed));
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R2", "reset pred_valid", {31'd0, pred_valid}, 32'd0);
    chk("R2", "reset pred_taken", {31'd0, pred_taken}, 32'd0);

    // directed corner cases in set 5, tag 42
    step(1, la(21'h42, 7'd5, 4'd0), 0, '0, 0, 0, '0, 0, "R5");
    step(0, '0, 1, la(21'h42, 7'd5, 4'd6), 1, 2'b00, 32'h0000_1000, 4'd0, "R10");
    step(1, la(21'h42, 7'd5, 4'd0), 0, '0, 0, 0, '0, 0, "R6");
    step(1, la(21'h42, 7'd5, 4'd0), 0, '0, 0, 0, '0, 0, "R8");
    step(1, la(21'h43, 7'd5, 4'd0), 0, '0, 0, 0, '0, 0, "R1");
    step(0, '0, 1, la(21'h42, 7'd5, 4'd9), 1, 2'b01, 32'h0000_2000, 4'd0, "R2");
    step(1, la(21'h42, 7'd5, 4'd7), 0, '0, 0, 0, '0, 0, "R3");
    step(1, la(21'h42, 7'd5, 4'd7), 0, '0, 0, 0, '0, 0, "R7");
    step(0, '0, 1, la(21'h42, 7'd5, 4'd6), 1, 2'b00, 32'h0000_3000, 4'd7, "R9");
    step(0, '0, 1, la(21'h42, 7'd5, 4'd6), 1, 2'b00, 32'h0000_3000, 4'd3, "R9");
    step(1, la(21'h42, 7'd5, 4'd0), 0, '0, 0, 0, '0, 0, "R12");
    step(1, la(21'h42, 7'd5, 4'd0), 1, la(21'h42, 7'd5, 4'd6), 0, 2'b00,
         32'h0000_3000, 4'd0, "R11");
    step(1, la(21'h42, 7'd5, 4'd0), 0, '0, 0, 0, '0, 0, "R11");
    // fill the set beyond its ways to exercise replacement
    for (int i = 0; i < 6; i++)
      step(0, '0, 1, la(21'h42, 7'd5, 4'(10 + i)), 1, 2'b11,
           32'h100 * (i + 1), 0, "R10");
    step(1, la(21'h42, 7'd5, 4'd0), 0, '0, 0, 0, '0, 0, "R4");

    // constrained random: few tags and sets so hits and conflicts are frequent
    for (int i = 0; i < 4000; i++) begin
      logic [20:0] ft, utg21;
      logic [1:0]  ty;
      ft    = ($urandom % 2) ? 21'h1AB : 21'h0C3;
      utg21 = ($urandom % 2) ? 21'h1AB : 21'h0C3;
      ty    = ($urandom % 10 < 6) ? 2'b00 : 2'($urandom % 4);
      step(($urandom % 4) != 0, la(ft, 7'($urandom % 2), 4'($urandom)),
           ($urandom % 2) == 1, la(utg21, 7'($urandom % 2), 4'($urandom)),
           1'($urandom), ty, $urandom, 4'($urandom),
           (i % 2 == 0) ? "R4" : "R8");
    end
    step(0, '0, 0, '0, 0, 0, '0, 0, "R2");
    step(0, '0, 0, '0, 0, 0, '0, 0, "R2");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule